// File: doc/BRIEF.md
# Network controller command register file

This block is the host-facing register file of a DMA Ethernet controller. It holds 64 sixteen-bit registers, reached over a plain word-wide bus where the address selects the register. One of them is the command register. Host writes to it are turned into one-cycle action pulses for the transmit, receive, timer, resource-read and address-table-load engines. The engines themselves sit outside this block. The command register also records which commands are still outstanding.

Every register has its own write rule:
- Some registers accept writes only while the controller is in software reset.
- Some keep only part of the written word.
- Some store the inverted value.
- A few are read-only.

The block also keeps the interrupt status and mask registers and drives a level interrupt. The engines report events through a status-set vector, which is ORed into the status register. They report command completion through three done strobes, and each strobe clears its command bit so that software can poll for completion.

Top module: `nic_cmd_regfile`

## Requirements
- R1: After a synchronous reset, the registers read as follows:
  - command register (index 0x00): 0x0094
  - mask (0x04) and status (0x05): 0
  - index 0x13: 0x02F8
  - index 0x03: 0x0101
  - index 0x02: 0x0020

  Also after reset, `irq` is low and `cmd_pulse` is zero.
- R2: When the command register is written outside reset, it ORs in `wdata & 0x03BF`. In the next cycle, `cmd_pulse` equals `wdata & 0x03BF` for one cycle. Bit 6 and bits 15:10 are never stored or pulsed. The bit positions are: 0 halt, 1 transmit, 2 receive off, 3 receive on, 4 timer stop, 5 timer start, 7 software reset, 8 resource read, 9 table load.
- R3: While command bit 7 is set, a command write with bit 7 clear only clears bit 7. It merges nothing else and pulses nothing.
- R4: A command write applies these side effects after the merge:
  - receive off (bit 2) clears receive on (bit 3), and receive on clears receive off;
  - timer stop (bit 4) clears timer start (bit 5), and timer start clears timer stop;
  - software reset (bit 7) clears bits 9, 8, 1 and 0, then sets bits 7 and 2.
- R5: A one-cycle strobe on `tx_done`, `rra_done` or `cam_done` clears command bit 1, 8 or 9 respectively.
- R6: The mask register keeps only bits 14:0. `irq` is high exactly when the mask ANDed with the status register is nonzero, and it updates on the same edge as those registers.
- R7: Writing the status register clears only those written-one bits that are currently set. Bits in `isr_set` are ORed in on the same edge. When a set and a clear hit the same bit together, the bit stays set.
- R8: Clearing status bit 5 through a status write pulses `cmd_pulse[8]` in the next cycle. A write of bit 5 while bit 5 is already clear pulses nothing.
- R9: Index 0x01 stores `wdata & 0xBFFF`, and index 0x3F stores `wdata & 0xF017`, but only while command bit 7 is set. Otherwise the write leaves the register unchanged.
- R10: Write masking by index:
  - index 0x03 keeps bits 15:12;
  - index 0x02 keeps bits 15:5;
  - indices 0x15 to 0x18 force bit 0 to zero;
  - indices 0x2C to 0x2E store `wdata ^ 0xFFFF`.
- R11: Writes to indices 0x22 to 0x24, 0x28 and 0x2F are ignored. These indices read back 0, except 0x28, which reads 0x0004.
- R12: Any other index stores the full written word. A read presents its data on `bus_rdata` in the cycle after `bus_rd`, and the data holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| isr_set | input | 16 | Per-bit status set events from the engines |
| tx_done | input | 1 | Transmit engine finished |
| rra_done | input | 1 | Resource read finished |
| cam_done | input | 1 | Address table load finished |
| cmd_pulse | output | 16 | One-cycle action pulses, bit positions as in the command register |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: `ADDR_W` = 6, `EOB_INIT` = 0x02F8 and `REV_ID` = 0x0004. With those defaults the whole 64-entry map is addressable, so every special index can be written and read back through the bus. The reset value at index 0x13 and the constant at 0x28 can be compared against fixed numbers. The command sequences walk the register into reset, out of it and back again. This reaches both the reset-gated writes and the leave-reset-only path. Set and clear collisions on the status register are driven in the same cycle to reach the set-wins case.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  localparam int WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  // register indices whose behaviour is special
  localparam int IDX_CR      = 'h00;
  localparam int IDX_DCR     = 'h01;
  localparam int IDX_RCR     = 'h02;
  localparam int IDX_TCR     = 'h03;
  localparam int IDX_IMR     = 'h04;
  localparam int IDX_ISR     = 'h05;
  localparam int IDX_EOB     = 'h13;
  localparam int IDX_EVEN_LO = 'h15;
  localparam int IDX_EVEN_HI = 'h18;
  localparam int IDX_RO_LO   = 'h22;
  localparam int IDX_RO_HI   = 'h24;
  localparam int IDX_CE      = 'h25;
  localparam int IDX_REV     = 'h28;
  localparam int IDX_SEQ     = 'h2B;
  localparam int IDX_INV_LO  = 'h2C;
  localparam int IDX_INV_HI  = 'h2E;
  localparam int IDX_RO_TOP  = 'h2F;
  localparam int IDX_DCR2    = 'h3F;

  // command bit positions
  localparam int CB_HALT  = 0;
  localparam int CB_TX    = 1;
  localparam int CB_RXOFF = 2;
  localparam int CB_RXON  = 3;
  localparam int CB_TSTOP = 4;
  localparam int CB_TGO   = 5;
  localparam int CB_SWRST = 7;
  localparam int CB_RRA   = 8;
  localparam int CB_CAM   = 9;

  localparam word_t CMD_MASK   = 16'h03BF;
  localparam word_t CLR_ON_RST = 16'h0303;
  localparam word_t CR_INIT    = 16'h0094;
  localparam word_t IMR_MASK   = 16'h7FFF;
  localparam word_t DCR_MASK   = 16'hBFFF;
  localparam word_t DCR2_MASK  = 16'hF017;
  localparam word_t TCR_MASK   = 16'hF000;
  localparam word_t RCR_MASK   = 16'hFFE0;
  localparam word_t EVEN_MASK  = 16'hFFFE;
  localparam word_t TCR_INIT   = 16'h0101;
  localparam word_t RCR_INIT   = 16'h0020;
  localparam int    ISR_RBE    = 5;

  typedef enum logic [2:0] {
    DST_NONE, DST_CR, DST_IMR, DST_ISR, DST_KEEP, DST_RAM
  } dest_e;

  // registers that need a reset value live in a small flop bank
  localparam int KS_DCR  = 0;
  localparam int KS_RCR  = 1;
  localparam int KS_TCR  = 2;
  localparam int KS_EOB  = 3;
  localparam int KS_CE   = 4;
  localparam int KS_SEQ  = 5;
  localparam int KS_DCR2 = 6;
  localparam int KEEP_N  = 7;
  localparam int SLOT_W  = $clog2(KEEP_N);

  function automatic int keep_slot(input int idx);
    case (idx)
      IDX_DCR:  return KS_DCR;
      IDX_RCR:  return KS_RCR;
      IDX_TCR:  return KS_TCR;
      IDX_EOB:  return KS_EOB;
      IDX_CE:   return KS_CE;
      IDX_SEQ:  return KS_SEQ;
      IDX_DCR2: return KS_DCR2;
      default:  return -1;
    endcase
  endfunction

  function automatic word_t keep_init(input int slot, input word_t eob);
    case (slot)
      KS_RCR:  return RCR_INIT;
      KS_TCR:  return TCR_INIT;
      KS_EOB:  return eob;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/nic_wr_shape.sv
module nic_wr_shape
  import nic_regs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] idx,
  input  word_t             wdata,
  input  logic              in_reset,
  output dest_e             dest,
  output word_t             shaped,
  output logic [SLOT_W-1:0] slot
);
  int i;
  int ks;

  always_comb begin
    i      = int'(idx);
    dest   = DST_RAM;
    shaped = wdata;
    slot   = '0;
    ks     = -1;
    if (i == IDX_CR) begin
      dest = DST_CR;
    end else if (i == IDX_IMR) begin
      dest = DST_IMR;
    end else if (i == IDX_ISR) begin
      dest = DST_ISR;
    end else if ((i >= IDX_RO_LO && i <= IDX_RO_HI) || i == IDX_REV || i == IDX_RO_TOP) begin
      dest = DST_NONE;
    end else if (i == IDX_DCR) begin
      shaped = wdata & DCR_MASK;
      if (!in_reset) dest = DST_NONE;
    end else if (i == IDX_DCR2) begin
      shaped = wdata & DCR2_MASK;
      if (!in_reset) dest = DST_NONE;
    end else if (i == IDX_TCR) begin
      shaped = wdata & TCR_MASK;
    end else if (i == IDX_RCR) begin
      shaped = wdata & RCR_MASK;
    end else if (i >= IDX_EVEN_LO && i <= IDX_EVEN_HI) begin
      shaped = wdata & EVEN_MASK;
    end else if (i >= IDX_INV_LO && i <= IDX_INV_HI) begin
      shaped = wdata ^ {WORD_W{1'b1}};
    end
    if (dest == DST_RAM) begin
      ks = keep_slot(i);
      if (ks >= 0) begin
        dest = DST_KEEP;
        slot = SLOT_W'(ks);
      end
    end
  end
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cr_we,
  input  word_t wdata,
  input  logic  tx_done,
  input  logic  rra_done,
  input  logic  cam_done,
  input  logic  rbe_req,
  output word_t cr_q,
  output word_t pulse_q
);
  word_t cr_d, pulse_d, done_m;

  always_comb begin
    done_m           = '0;
    done_m[CB_TX]    = tx_done;
    done_m[CB_RRA]   = rra_done;
    done_m[CB_CAM]   = cam_done;
    cr_d             = cr_q & ~done_m;
    pulse_d          = '0;
    if (cr_we) begin
      if (cr_q[CB_SWRST] && !wdata[CB_SWRST]) begin
        cr_d[CB_SWRST] = 1'b0;
      end else begin
        cr_d    = cr_d | (wdata & CMD_MASK);
        pulse_d = wdata & CMD_MASK;
        if (wdata[CB_RXOFF]) cr_d[CB_RXON]  = 1'b0;
        if (wdata[CB_RXON])  cr_d[CB_RXOFF] = 1'b0;
        if (wdata[CB_TSTOP]) cr_d[CB_TGO]   = 1'b0;
        if (wdata[CB_TGO])   cr_d[CB_TSTOP] = 1'b0;
        if (wdata[CB_SWRST]) begin
          cr_d           = cr_d & ~CLR_ON_RST;
          cr_d[CB_SWRST] = 1'b1;
          cr_d[CB_RXOFF] = 1'b1;
        end
      end
    end
    if (rbe_req) pulse_d[CB_RRA] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q    <= CR_INIT;
      pulse_q <= '0;
    end else begin
      cr_q    <= cr_d;
      pulse_q <= pulse_d;
    end
  end

  p_pulse_follows_write_r2: assert property (@(posedge clk) disable iff (rst)
    (cr_we && !cr_q[CB_SWRST]) |=> (pulse_q == ($past(wdata) & CMD_MASK)));

  p_leave_reset_only_r3: assert property (@(posedge clk) disable iff (rst)
    (cr_we && cr_q[CB_SWRST] && !wdata[CB_SWRST]) |=> (pulse_q == '0 && !cr_q[CB_SWRST]));

  p_swrst_effect_r4: assert property (@(posedge clk) disable iff (rst)
    (cr_we && wdata[CB_SWRST]) |=> (cr_q[CB_SWRST] && cr_q[CB_RXOFF] && ((cr_q & CLR_ON_RST) == '0)));

  p_tx_done_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !cr_we) |=> !cr_q[CB_TX]);
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
  import nic_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  imr_we,
  input  logic  isr_we,
  input  word_t wdata,
  input  word_t isr_set,
  output word_t imr_q,
  output word_t isr_q,
  output logic  irq_q,
  output logic  rbe_cleared
);
  word_t clr, isr_d, imr_d;

  always_comb begin
    clr         = isr_we ? (wdata & isr_q) : '0;
    isr_d       = (isr_q & ~clr) | isr_set;
    imr_d       = imr_we ? (wdata & IMR_MASK) : imr_q;
    rbe_cleared = clr[ISR_RBE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imr_q <= '0;
      isr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      imr_q <= imr_d;
      isr_q <= isr_d;
      irq_q <= |(imr_d & isr_d);
    end
  end

  p_irq_tracks_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(imr_q & isr_q));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (|isr_set) |=> ((isr_q & $past(isr_set)) == $past(isr_set)));
endmodule

// File: rtl/nic_reg_store.sv
module nic_reg_store
  import nic_regs_pkg::*;
#(
  parameter int    ADDR_W   = 6,
  parameter word_t EOB_INIT = 16'h02F8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ram_we,
  input  logic              keep_we,
  input  logic [SLOT_W-1:0] keep_slot_w,
  input  logic [ADDR_W-1:0] waddr,
  input  word_t             wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output word_t             rd_word
);
  localparam int DEPTH = 2 ** ADDR_W;

  word_t             mem [DEPTH];
  word_t             mem_q;
  word_t             keep_q [KEEP_N];
  logic              hit_q;
  logic [SLOT_W-1:0] hit_slot_q;
  int                rs;

  // plain storage: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (ram_we) mem[waddr] <= wdata;
    if (re)     mem_q      <= mem[raddr];
  end

  for (genvar k = 0; k < KEEP_N; k++) begin : g_keep
    always_ff @(posedge clk) begin
      if (rst)                                keep_q[k] <= keep_init(k, EOB_INIT);
      else if (keep_we && keep_slot_w == SLOT_W'(k)) keep_q[k] <= wdata;
    end
  end

  always_comb rs = keep_slot(int'(raddr));

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q      <= 1'b0;
      hit_slot_q <= '0;
    end else if (re) begin
      hit_q      <= (rs >= 0);
      hit_slot_q <= (rs >= 0) ? SLOT_W'(rs) : '0;
    end
  end

  assign rd_word = hit_q ? keep_q[hit_slot_q] : mem_q;
endmodule

// File: rtl/nic_cmd_regfile.sv
module nic_cmd_regfile
  import nic_regs_pkg::*;
#(
  parameter int    ADDR_W   = 6,
  parameter word_t EOB_INIT = 16'h02F8,
  parameter word_t REV_ID   = 16'h0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [15:0]       isr_set,
  input  logic              tx_done,
  input  logic              rra_done,
  input  logic              cam_done,
  output logic [15:0]       cmd_pulse,
  output logic              irq
);
  dest_e             dest;
  word_t             shaped;
  logic [SLOT_W-1:0] slot;
  word_t             cr_q, pulse_q, imr_q, isr_q, store_rd;
  logic              irq_q, rbe_cleared;
  logic              spec_hit, spec_sel_q;
  word_t             spec_val, spec_q;

  nic_wr_shape #(.ADDR_W(ADDR_W)) u_shape (
    .idx      (bus_addr),
    .wdata    (bus_wdata),
    .in_reset (cr_q[CB_SWRST]),
    .dest     (dest),
    .shaped   (shaped),
    .slot     (slot)
  );

  nic_cmd_ctrl u_cmd (
    .clk      (clk),
    .rst      (rst),
    .cr_we    (bus_wr && dest == DST_CR),
    .wdata    (bus_wdata),
    .tx_done  (tx_done),
    .rra_done (rra_done),
    .cam_done (cam_done),
    .rbe_req  (rbe_cleared),
    .cr_q     (cr_q),
    .pulse_q  (pulse_q)
  );

  nic_irq_unit u_irq (
    .clk         (clk),
    .rst         (rst),
    .imr_we      (bus_wr && dest == DST_IMR),
    .isr_we      (bus_wr && dest == DST_ISR),
    .wdata       (bus_wdata),
    .isr_set     (isr_set),
    .imr_q       (imr_q),
    .isr_q       (isr_q),
    .irq_q       (irq_q),
    .rbe_cleared (rbe_cleared)
  );

  nic_reg_store #(.ADDR_W(ADDR_W), .EOB_INIT(EOB_INIT)) u_store (
    .clk         (clk),
    .rst         (rst),
    .ram_we      (bus_wr && dest == DST_RAM),
    .keep_we     (bus_wr && dest == DST_KEEP),
    .keep_slot_w (slot),
    .waddr       (bus_addr),
    .wdata       (shaped),
    .re          (bus_rd),
    .raddr       (bus_addr),
    .rd_word     (store_rd)
  );

  // read side for registers held outside the store
  always_comb begin
    spec_hit = 1'b1;
    spec_val = '0;
    if (bus_addr == ADDR_W'(IDX_CR))       spec_val = cr_q;
    else if (bus_addr == ADDR_W'(IDX_IMR)) spec_val = imr_q;
    else if (bus_addr == ADDR_W'(IDX_ISR)) spec_val = isr_q;
    else if (bus_addr == ADDR_W'(IDX_REV)) spec_val = REV_ID;
    else if ((bus_addr >= ADDR_W'(IDX_RO_LO) && bus_addr <= ADDR_W'(IDX_RO_HI)) ||
             bus_addr == ADDR_W'(IDX_RO_TOP)) spec_val = '0;
    else spec_hit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_sel_q <= 1'b1;
      spec_q     <= '0;
    end else if (bus_rd) begin
      spec_sel_q <= spec_hit;
      spec_q     <= spec_val;
    end
  end

  assign bus_rdata = spec_sel_q ? spec_q : store_rd;
  assign cmd_pulse = pulse_q;
  assign irq       = irq_q;

  p_rbe_clear_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(IDX_ISR) && bus_wdata[ISR_RBE] && isr_q[ISR_RBE])
      |=> cmd_pulse[CB_RRA]);
endmodule

// File: tb/tb_nic_cmd_regfile.sv
module tb_nic_cmd_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata, isr_set, cmd_pulse;
  logic        tx_done, rra_done, cam_done, irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic        finished = 1'b0;
  logic [15:0] last_pulse;
  logic [15:0] rv;

  always #10 clk = ~clk;

  nic_cmd_regfile dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .isr_set(isr_set),
    .tx_done(tx_done), .rra_done(rra_done), .cam_done(cam_done),
    .cmd_pulse(cmd_pulse), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // one bus cycle; pulses produced by it are captured in last_pulse
  task automatic cyc(input logic w, input logic [5:0] a, input logic [15:0] d,
                     input logic [15:0] s, input logic [2:0] dn);
    bus_wr = w; bus_addr = a; bus_wdata = d; isr_set = s;
    tx_done = dn[0]; rra_done = dn[1]; cam_done = dn[2];
    @(negedge clk);
    last_pulse = cmd_pulse;
    bus_wr = 1'b0; isr_set = '0; tx_done = 1'b0; rra_done = 1'b0; cam_done = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 16'h0, 3'b000);
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    rd(6'h00, rv); check("R1 cr", rv, 16'h0094);
    rd(6'h04, rv); check("R1 imr", rv, 16'h0000);
    rd(6'h05, rv); check("R1 isr", rv, 16'h0000);
    rd(6'h13, rv); check("R1 eob", rv, 16'h02F8);
    rd(6'h03, rv); check("R1 tcr", rv, 16'h0101);
    rd(6'h02, rv); check("R1 rcr", rv, 16'h0020);
    check("R1 irq", {15'h0, irq}, 16'h0);
    check("R1 pulse", cmd_pulse, 16'h0);
  endtask

  task automatic t_reset_gate;
    wr(6'h01, 16'hFFFF); rd(6'h01, rv); check("R9 dcr in reset", rv, 16'hBFFF);
    wr(6'h3F, 16'hFFFF); rd(6'h3F, rv); check("R9 dcr2 in reset", rv, 16'hF017);
    wr(6'h00, 16'h0002);
    check("R3 no pulse", last_pulse, 16'h0);
    rd(6'h00, rv); check("R3 only rst cleared", rv, 16'h0014);
    wr(6'h01, 16'h1234); rd(6'h01, rv); check("R9 dcr locked", rv, 16'hBFFF);
    wr(6'h3F, 16'h0000); rd(6'h3F, rv); check("R9 dcr2 locked", rv, 16'hF017);
  endtask

  task automatic t_commands;
    wr(6'h00, 16'h0042);
    check("R2 tx pulse", last_pulse, 16'h0002);
    rd(6'h00, rv); check("R2 merge, bit6 dropped", rv, 16'h0016);
    check("R2 pulse one cycle", cmd_pulse, 16'h0);
    cyc(1'b0, 6'h00, 16'h0, 16'h0, 3'b001);
    rd(6'h00, rv); check("R5 tx_done", rv, 16'h0014);
    wr(6'h00, 16'h0028);
    check("R2 start pulses", last_pulse, 16'h0028);
    rd(6'h00, rv); check("R4 rxon/tgo", rv, 16'h0028);
    wr(6'h00, 16'h0014);
    rd(6'h00, rv); check("R4 rxoff/tstop", rv, 16'h0014);
    wr(6'h00, 16'h0300);
    check("R2 rra/cam pulse", last_pulse, 16'h0300);
    rd(6'h00, rv); check("R2 rra/cam pending", rv, 16'h0314);
    cyc(1'b0, 6'h00, 16'h0, 16'h0, 3'b010);
    rd(6'h00, rv); check("R5 rra_done", rv, 16'h0214);
    cyc(1'b0, 6'h00, 16'h0, 16'h0, 3'b100);
    rd(6'h00, rv); check("R5 cam_done", rv, 16'h0014);
    wr(6'h00, 16'h0283);
    check("R2 swrst pulses", last_pulse, 16'h0283);
    rd(6'h00, rv); check("R4 swrst clears", rv, 16'h0094);
    wr(6'h00, 16'h0080);
    check("R3 rst write pulses", last_pulse, 16'h0080);
    rd(6'h00, rv); check("R4 stays in reset", rv, 16'h0094);
    wr(6'h00, 16'h0000);
    rd(6'h00, rv); check("R3 leave reset", rv, 16'h0014);
  endtask

  task automatic t_irq;
    wr(6'h04, 16'hFFFF); rd(6'h04, rv); check("R6 imr mask", rv, 16'h7FFF);
    cyc(1'b0, 6'h00, 16'h0, 16'h8000, 3'b000);
    check("R6 bit15 no irq", {15'h0, irq}, 16'h0);
    cyc(1'b0, 6'h00, 16'h0, 16'h0080, 3'b000);
    check("R6 irq high", {15'h0, irq}, 16'h1);
    wr(6'h05, 16'h0001); rd(6'h05, rv); check("R7 clear unset bit", rv, 16'h8080);
    wr(6'h05, 16'h0080);
    check("R6 irq low", {15'h0, irq}, 16'h0);
    rd(6'h05, rv); check("R7 w1c", rv, 16'h8000);
    cyc(1'b0, 6'h00, 16'h0, 16'h0400, 3'b000);
    cyc(1'b1, 6'h05, 16'h0400, 16'h0400, 3'b000);
    rd(6'h05, rv); check("R7 set wins", rv, 16'h8400);
    check("R6 irq kept", {15'h0, irq}, 16'h1);
    wr(6'h05, 16'h8400); rd(6'h05, rv); check("R7 clear all", rv, 16'h0000);
  endtask

  task automatic t_rbe;
    cyc(1'b0, 6'h00, 16'h0, 16'h0020, 3'b000);
    wr(6'h05, 16'h0020);
    check("R8 rra pulse", last_pulse, 16'h0100);
    wr(6'h05, 16'h0020);
    check("R8 no pulse when clear", last_pulse, 16'h0000);
  endtask

  task automatic t_masks;
    wr(6'h03, 16'hFFFF); rd(6'h03, rv); check("R10 tcr", rv, 16'hF000);
    wr(6'h02, 16'hFFFF); rd(6'h02, rv); check("R10 rcr", rv, 16'hFFE0);
    wr(6'h15, 16'hFFFF); rd(6'h15, rv); check("R10 even lo", rv, 16'hFFFE);
    wr(6'h18, 16'h1235); rd(6'h18, rv); check("R10 even hi", rv, 16'h1234);
    wr(6'h2C, 16'h00FF); rd(6'h2C, rv); check("R10 inv lo", rv, 16'hFF00);
    wr(6'h2E, 16'hFFFF); rd(6'h2E, rv); check("R10 inv hi", rv, 16'h0000);
    wr(6'h0D, 16'hA5A5); rd(6'h0D, rv); check("R12 plain", rv, 16'hA5A5);
    wr(6'h3E, 16'h5A5A); rd(6'h3E, rv); check("R12 plain top", rv, 16'h5A5A);
    wr(6'h13, 16'h0123); rd(6'h13, rv); check("R12 eob rewrite", rv, 16'h0123);
  endtask

  task automatic t_readonly;
    wr(6'h22, 16'hFFFF); rd(6'h22, rv); check("R11 ro 22", rv, 16'h0000);
    wr(6'h24, 16'hFFFF); rd(6'h24, rv); check("R11 ro 24", rv, 16'h0000);
    wr(6'h28, 16'hFFFF); rd(6'h28, rv); check("R11 rev", rv, 16'h0004);
    wr(6'h2F, 16'hFFFF); rd(6'h2F, rv); check("R11 ro 2f", rv, 16'h0000);
  endtask

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    isr_set = '0; tx_done = 1'b0; rra_done = 1'b0; cam_done = 1'b0;
    last_pulse = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reset_gate();
    t_commands();
    t_irq();
    t_rbe();
    t_masks();
    t_readonly();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule